// File: doc/BRIEF.md
# Stepped-Frequency Loop Reference Source

This block generates a square-wave reference for exercising a phase-locked loop. It runs from a fast system clock. A prescaler divides that clock into a regular tick. The reference changes level on every tick in the fast rate, and on every `SLOW_DIV`-th tick in the slow rate. With the default parameters and a 50 MHz clock, a tick comes every 50 µs, so the reference is 10 kHz in the fast rate and 5 kHz in the slow rate.

The two rates alternate on a fixed interval, 10000 ticks by default, which is half a second. Each change gives the loop under test a frequency step it has to re-acquire. A change falls due when the interval counter wraps. It then waits for the next reference edge, so no half-period is ever cut short. A one-clock marker output flags the clock on which each change takes effect, so an instrument can trigger on it. The reference also appears on a separate probe output.

The block also turns two active-low pump enables from an external phase comparator into two one-sided pin controls. Each pin control is a drive level plus an output enable. The up pin can only pull high, and the down pin can only pull low.

Top module: `stepref_gen`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `ref_o`, `ref_probe_o` and `step_mark_o` are 0, the prescaler and the interval counter are cleared, and the block is in the fast rate.
- R2: A tick occurs once every `PRESCALE_DIV` clocks. The first tick after reset is released is on the `PRESCALE_DIV`-th rising edge. The reference never changes except on a tick edge.
- R3: In the fast rate the reference inverts on every tick, so each half-period is `PRESCALE_DIV` clocks.
- R4: In the slow rate the reference inverts on every `SLOW_DIV`-th tick after the rate change, so each half-period is `SLOW_DIV*PRESCALE_DIV` clocks.
- R5: A rate change falls due every `INTERVAL_TICKS` ticks, counted from reset without regard to rate changes. The rate alternates fast, slow, fast, and so on.
- R6: A due change takes effect only on a tick where the reference inverts, and it is deferred to the next such tick if needed. Every half-period is therefore exactly one of the two legal lengths.
- R7: `step_mark_o` is high for exactly one clock. It rises on the same edge as the reference inversion that carries the rate change.
- R8: `up_drv_o` is always 1, and `up_oe_o` is 1 exactly when `up_en_n` is 0 (in the same cycle, with no register).
- R9: `dn_drv_o` is always 0, and `dn_oe_o` is 1 exactly when `dn_en_n` is 0 (in the same cycle, with no register).
- R10: Whenever the two pump enables are not both low, `up_oe_o` and `dn_oe_o` are never 1 together.
- R11: `ref_probe_o` equals `ref_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| up_en_n | input | 1 | Pump-up enable from the comparator, active low |
| dn_en_n | input | 1 | Pump-down enable from the comparator, active low |
| ref_o | output | 1 | Stepped-frequency reference |
| ref_probe_o | output | 1 | Copy of the reference for observation |
| step_mark_o | output | 1 | One-clock pulse when the rate changes |
| up_drv_o | output | 1 | Drive level for the up pin (high) |
| up_oe_o | output | 1 | Output enable for the up pin |
| dn_drv_o | output | 1 | Drive level for the down pin (low) |
| dn_oe_o | output | 1 | Output enable for the down pin |

## Verification
The pin controls are combinational. The bench therefore checks them one time step after it drives new pump enables, within the same low clock phase. The reference and the marker are registered, and they change on the rising edge that ends a tick cycle: the first one is `PRESCALE_DIV` edges after reset is released. The bench keeps its own count of rising edges since reset. At each falling edge it advances its reference model by exactly one edge and then compares the reference and the marker. Half-period lengths are measured between observed reference changes, and the ticks carrying the first two markers are compared with computed due-and-deferred positions.

// File: rtl/stepref_pkg.sv
package stepref_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  // counter width able to hold 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic rate_e other_rate(rate_e r);
    return (r == RATE_FAST) ? RATE_SLOW : RATE_FAST;
  endfunction

endpackage

// File: rtl/stepref_prescaler.sv
module stepref_prescaler #(
  parameter int unsigned DIV = 2500
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned    CW   = stepref_pkg::cnt_bits(DIV);
  localparam logic [CW-1:0]  LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/stepref_sequencer.sv
module stepref_sequencer
  import stepref_pkg::*;
#(
  parameter int unsigned INTERVAL_TICKS = 10000,
  parameter int unsigned SLOW_DIV       = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick_i,
  output logic  toggle_o,
  output logic  step_o,
  output rate_e rate_o
);
  localparam int unsigned   IW     = cnt_bits(INTERVAL_TICKS);
  localparam int unsigned   PW     = cnt_bits(SLOW_DIV);
  localparam logic [IW-1:0] I_LAST = IW'(INTERVAL_TICKS - 1);
  localparam logic [PW-1:0] P_LAST = PW'(SLOW_DIV - 1);

  logic [IW-1:0] icnt_q;
  logic [PW-1:0] phase_q;
  logic          pend_q;
  rate_e         rate_q;
  logic          wrap_now;

  assign wrap_now = tick_i && (icnt_q == I_LAST);
  assign toggle_o = tick_i && ((rate_q == RATE_FAST) || (phase_q == P_LAST));
  assign step_o   = toggle_o && (pend_q || wrap_now);
  assign rate_o   = rate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt_q  <= '0;
      phase_q <= '0;
      pend_q  <= 1'b0;
      rate_q  <= RATE_FAST;
    end else if (tick_i) begin
      icnt_q <= wrap_now ? '0 : icnt_q + 1'b1;
      if (step_o) begin
        pend_q  <= 1'b0;
        rate_q  <= other_rate(rate_q);
        phase_q <= '0;
      end else begin
        if (wrap_now) pend_q <= 1'b1;
        if (rate_q == RATE_SLOW)
          phase_q <= (phase_q == P_LAST) ? '0 : phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stepref_shaper.sv
module stepref_shaper (
  input  logic clk,
  input  logic rst,
  input  logic toggle_i,
  input  logic step_i,
  output logic ref_o,
  output logic mark_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_o  <= 1'b0;
      mark_o <= 1'b0;
    end else begin
      ref_o  <= ref_o ^ toggle_i;
      mark_o <= step_i;
    end
  end
endmodule

// File: rtl/stepref_pump_pin.sv
module stepref_pump_pin #(
  parameter bit DRIVE_LEVEL = 1'b1
) (
  input  logic en_n_i,
  output logic drv_o,
  output logic oe_o
);
  assign drv_o = DRIVE_LEVEL;
  assign oe_o  = ~en_n_i;
endmodule

// File: rtl/stepref_gen.sv
module stepref_gen
  import stepref_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV   = 2500,
  parameter int unsigned INTERVAL_TICKS = 10000,
  parameter int unsigned SLOW_DIV       = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic up_en_n,
  input  logic dn_en_n,
  output logic ref_o,
  output logic ref_probe_o,
  output logic step_mark_o,
  output logic up_drv_o,
  output logic up_oe_o,
  output logic dn_drv_o,
  output logic dn_oe_o
);
  // named internal events, visible to the bound checker
  logic  tick_w;
  logic  toggle_w;
  logic  step_w;
  rate_e rate_w;
  logic  rate_slow_w;
  logic  ref_w;

  stepref_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk(clk), .rst(rst), .tick_o(tick_w)
  );

  stepref_sequencer #(.INTERVAL_TICKS(INTERVAL_TICKS), .SLOW_DIV(SLOW_DIV)) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick_w),
    .toggle_o(toggle_w), .step_o(step_w), .rate_o(rate_w)
  );

  stepref_shaper u_shape (
    .clk(clk), .rst(rst), .toggle_i(toggle_w), .step_i(step_w),
    .ref_o(ref_w), .mark_o(step_mark_o)
  );

  assign rate_slow_w = (rate_w == RATE_SLOW);
  assign ref_o       = ref_w;
  assign ref_probe_o = ref_w;

  stepref_pump_pin #(.DRIVE_LEVEL(1'b1)) u_up_pin (
    .en_n_i(up_en_n), .drv_o(up_drv_o), .oe_o(up_oe_o)
  );

  stepref_pump_pin #(.DRIVE_LEVEL(1'b0)) u_dn_pin (
    .en_n_i(dn_en_n), .drv_o(dn_drv_o), .oe_o(dn_oe_o)
  );
endmodule

// File: rtl/stepref_chk.sv
module stepref_chk #(
  parameter int unsigned DIV = 2500
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic slow,
  input logic tog_ref,
  input logic probe,
  input logic mark,
  input logic up_en_n,
  input logic dn_en_n,
  input logic up_drv,
  input logic up_oe,
  input logic dn_drv,
  input logic dn_oe
);
  // cycles since the last tick or reset, for the tick-spacing window
  logic [31:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || tick) gap_q <= '0;
    else             gap_q <= gap_q + 32'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!tog_ref && !mark && !slow));

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == 32'(DIV - 1)));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tog_ref));

  a_r3_fast_inverts: assert property (@(posedge clk) disable iff (rst)
    (tick && !slow) |=> (tog_ref != $past(tog_ref)));

  a_r6_change_on_edge: assert property (@(posedge clk) disable iff (rst)
    (slow != $past(slow)) |-> (tog_ref != $past(tog_ref)));

  a_r7_mark_narrow: assert property (@(posedge clk) disable iff (rst)
    mark |=> !mark);

  a_r7_mark_with_change: assert property (@(posedge clk) disable iff (rst)
    mark |-> (slow != $past(slow)));

  a_r8_up_pin: assert property (@(posedge clk) disable iff (rst)
    (up_drv == 1'b1) && (up_oe == !up_en_n));

  a_r9_dn_pin: assert property (@(posedge clk) disable iff (rst)
    (dn_drv == 1'b0) && (dn_oe == !dn_en_n));

  a_r10_pins_exclusive: assert property (@(posedge clk) disable iff (rst)
    (up_en_n || dn_en_n) |-> !(up_oe && dn_oe));

  a_r11_probe_copy: assert property (@(posedge clk) disable iff (rst)
    probe == tog_ref);
endmodule

bind stepref_gen stepref_chk #(.DIV(PRESCALE_DIV)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .slow(rate_slow_w),
  .tog_ref(ref_o), .probe(ref_probe_o), .mark(step_mark_o),
  .up_en_n(up_en_n), .dn_en_n(dn_en_n),
  .up_drv(up_drv_o), .up_oe(up_oe_o), .dn_drv(dn_drv_o), .dn_oe(dn_oe_o)
);

// File: tb/test_stepref_gen.sv
`timescale 1ns/1ps
module test_stepref_gen;
  localparam int DIV  = 3;
  localparam int INT  = 5;
  localparam int SLOW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_en_n = 1'b1;
  logic dn_en_n = 1'b1;
  logic ref_o, ref_probe_o, step_mark_o;
  logic up_drv_o, up_oe_o, dn_drv_o, dn_oe_o;

  always #5 clk = ~clk;

  stepref_gen #(.PRESCALE_DIV(DIV), .INTERVAL_TICKS(INT), .SLOW_DIV(SLOW)) i_stepref_gen (
    .clk(clk), .rst(rst), .up_en_n(up_en_n), .dn_en_n(dn_en_n),
    .ref_o(ref_o), .ref_probe_o(ref_probe_o), .step_mark_o(step_mark_o),
    .up_drv_o(up_drv_o), .up_oe_o(up_oe_o), .dn_drv_o(dn_drv_o), .dn_oe_o(dn_oe_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // independent tick-level model: state is the last change tick and the next due boundary
  int m_sw, m_due;
  bit m_slow, m_ref, m_mark;

  task automatic model_reset();
    m_sw = 0; m_due = INT; m_slow = 1'b0; m_ref = 1'b0; m_mark = 1'b0;
  endtask

  function automatic bit inverts_on(int k);
    if (!m_slow) return 1'b1;
    return ((k - m_sw) % SLOW) == 0;
  endfunction

  // first slow-rate inversion tick at or after boundary b, starting from change tick s
  function automatic int slow_edge_from(int s, int b);
    return s + SLOW * ((b - s + SLOW - 1) / SLOW);
  endfunction

  task automatic model_edge(input int n);
    m_mark = 1'b0;
    if (n % DIV == 0) begin
      int k = n / DIV;
      if (inverts_on(k)) begin
        m_ref = ~m_ref;
        if (k >= m_due) begin
          m_slow = ~m_slow; m_sw = k; m_due += INT; m_mark = 1'b1;
        end
      end
    end
  endtask

  task automatic drive_pumps();
    int r = $urandom % 3;
    up_en_n = (r != 1);
    dn_en_n = (r != 2);
  endtask

  task automatic check_pins();
    #1;
    chk(up_drv_o == 1'b1 && up_oe_o == !up_en_n, "R8 up pin", {up_drv_o, up_oe_o}, {1'b1, !up_en_n});
    chk(dn_drv_o == 1'b0 && dn_oe_o == !dn_en_n, "R9 down pin", {dn_drv_o, dn_oe_o}, {1'b0, !dn_en_n});
    chk(!(up_oe_o && dn_oe_o), "R10 both pins enabled", {up_oe_o, dn_oe_o}, 0);
  endtask

  int last_chg, mark_cnt, mark_tick0, mark_tick1;
  logic prev_ref;

  task automatic run_edges(input int count);
    for (int n = 1; n <= count; n++) begin
      @(negedge clk);
      model_edge(n);
      chk(ref_o == m_ref, "R3/R4/R5 reference level", ref_o, m_ref);
      chk(step_mark_o == m_mark, "R7 marker", step_mark_o, m_mark);
      chk(ref_probe_o == ref_o, "R11 probe copy", ref_probe_o, ref_o);
      if (ref_o !== prev_ref) begin
        int len = n - last_chg;
        chk(len == DIV || len == DIV * SLOW, "R6 half-period length", len, DIV);
        if (last_chg == 0) chk(n == DIV, "R2 first tick edge", n, DIV);
        last_chg = n;
      end
      if (step_mark_o) begin
        if (mark_cnt == 0) mark_tick0 = n / DIV;
        if (mark_cnt == 1) mark_tick1 = n / DIV;
        mark_cnt++;
      end
      prev_ref = ref_o;
      drive_pumps();
      check_pins();
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(ref_o == 1'b0, "R1 reset reference", ref_o, 0);
    chk(step_mark_o == 1'b0, "R1 reset marker", step_mark_o, 0);
    rst = 1'b0;
    model_reset();
    last_chg = 0; mark_cnt = 0; prev_ref = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // directed pin corners, R8 R9 R10
    up_en_n = 1'b0; dn_en_n = 1'b1; check_pins();
    up_en_n = 1'b1; dn_en_n = 1'b0; check_pins();
    up_en_n = 1'b1; dn_en_n = 1'b1; check_pins();
    run_edges(360);
    // R5: first change due and taken at tick INT (fast rate), R6: second deferred to a slow edge
    chk(mark_tick0 == INT, "R5 first change tick", mark_tick0, INT);
    chk(mark_tick1 == slow_edge_from(INT, 2 * INT), "R6 deferred change tick",
        mark_tick1, slow_edge_from(INT, 2 * INT));
    chk(mark_cnt >= 10, "R5 changes keep alternating", mark_cnt, 10);
    // mid-run reset restarts the sequence in the fast rate (R1)
    do_reset();
    run_edges(60);
    chk(mark_tick0 == INT, "R1 restart fast rate", mark_tick0, INT);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule